// File: doc/BRIEF.md
# IP Destination Address Packet Filter

This block sits inline on a 128-bit frame stream (one beat per transfer, each beat carrying data, a byte count, an end-of-frame flag and a cancel flag) and forwards every beat through one register stage. While filtering is switched on, it reads the EtherType, the IP version nibble and the destination address of IPv4 and IPv6 frames as the header beats go past. When the destination does not equal the configured local address, it cancels the frame downstream by raising the output cancel flag. The beat that completes the address is not forwarded.

The drop decision is made on the fly. The IPv4 destination spans the second and third beats, and the IPv6 destination spans the third and fourth. A rejected frame is therefore never buffered. Beats already forwarded stay forwarded, a single cancel follows, and the rest of the frame is swallowed at full rate. Clearing the enable input gives promiscuous operation. A cancel that arrives on the input stream is passed on and restarts frame tracking.

Beats are 16 bytes in little-endian lane order: frame byte n of a beat sits at bits [8n+7:8n].

Top module: `ip_dest_filter`

## Requirements
- R1: After reset, `m_valid` and `m_abort` are low.
- R2: A beat accepted on the input (`s_valid && s_ready && !s_abort`) of a frame that is not being dropped appears on the output on the next cycle with identical data, byte count and last flag. Beat order is preserved. While `m_valid && !m_ready` the output holds steady, and `s_ready` is high whenever the output register is empty or being emptied.
- R3: The EtherType is read from bits [111:96] of the first beat, where 16'h0008 means IPv4 and 16'hDD86 means IPv6. A frame with any other value passes unchanged.
- R4: An IPv4 frame whose version nibble (first beat bits [119:116]) is 4 and whose destination (frame bytes 30..33, most significant byte first, located at second beat bits [127:112] and third beat bits [15:0]) equals `local_v4` passes unchanged.
- R5: With filtering on, an IPv4 frame that has a wrong version nibble or a mismatching destination has its first two beats forwarded. In place of the third beat, one `m_abort` is emitted.
- R6: IPv6 frames need version nibble 6, and the destination (frame bytes 38..53) must equal `local_v6`, where byte 38 is compared with bits [127:120]. The verdict falls on the fourth beat. A match passes unchanged. A failure forwards the first three beats and then emits one `m_abort`.
- R7: With `filter_en` low, `m_abort` is raised only in response to an input cancel. The block itself never rejects a frame.
- R8: A frame whose last beat comes before its deciding beat (the third beat for IPv4, the fourth for IPv6) passes unchanged, whatever its header holds.
- R9: An input cancel taken while `s_ready` is high produces `m_abort` with `m_valid` low on the next cycle. Any beat offered alongside it is discarded, and the next beat is treated as the first beat of a new frame.
- R10: After a filter cancel, the remaining beats of that frame are accepted with `s_ready` held high, even while `m_ready` is low. They are not forwarded. Tracking restarts after the last beat.
- R11: `m_abort` is never high in the same cycle as `m_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| filter_en | input | 1 | 1 = filter by destination address, 0 = promiscuous |
| local_v4 | input | 32 | Local IPv4 address |
| local_v6 | input | 128 | Local IPv6 address |
| s_valid | input | 1 | Input beat valid |
| s_ready | output | 1 | Input beat accepted |
| s_data | input | 128 | Input beat data, little-endian byte lanes |
| s_bytes | input | 4 | Valid bytes in a last beat, 0 meaning 16 |
| s_last | input | 1 | Input beat ends the frame |
| s_abort | input | 1 | Input frame cancel |
| m_valid | output | 1 | Output beat valid |
| m_ready | input | 1 | Downstream accepts the output beat |
| m_data | output | 128 | Output beat data |
| m_bytes | output | 4 | Output byte count |
| m_last | output | 1 | Output beat ends the frame |
| m_abort | output | 1 | Output frame cancel |

## Verification
Directed frames cover the following cases:
- matching and mismatching IPv4 and IPv6 destinations, with the wrong byte placed at the first and last address positions so that each beat-straddling comparison is separated from its neighbour;
- wrong version nibbles;
- a near-miss EtherType;
- runt frames that end one beat before the verdict;
- a rejected frame that ends exactly on its deciding beat.

Promiscuous frames show that the enable gates only the filter verdict. An input cancel in the middle of a frame, followed by a clean frame, shows that frame state really restarts. Random frame lengths, kinds, mismatches and back-pressure are compared against a byte-indexed reference model.

// File: rtl/ipf_pkg.sv
`timescale 1ns/1ps
// Package: shared types and constants for the IP destination filter.
// Assumes 16-byte little-endian beats; lane values are as seen on the bus.
package ipf_pkg;

    typedef enum logic [1:0] {
        FK_OTHER = 2'd0,
        FK_V4    = 2'd1,
        FK_V6    = 2'd2
    } frame_kind_e;

    // EtherType as it appears in first-beat bits [111:96] (byte 12 in low lane)
    localparam logic [15:0] ETYPE_V4_LANES = 16'h0008;
    localparam logic [15:0] ETYPE_V6_LANES = 16'hDD86;
    localparam logic [3:0]  VER_V4 = 4'd4;
    localparam logic [3:0]  VER_V6 = 4'd6;

    // Beat position counter stops here, past the last deciding beat
    localparam int POS_LIMIT = 4;

    // Reverse byte order of a 32-bit value (MSB byte lands in lane 0)
    function automatic logic [31:0] swap_bytes32(input logic [31:0] v);
        logic [31:0] r;
        for (int k = 0; k < 4; k++) r[8*k +: 8] = v[31-8*k -: 8];
        return r;
    endfunction

    // Reverse byte order of a 128-bit value
    function automatic logic [127:0] swap_bytes128(input logic [127:0] v);
        logic [127:0] r;
        for (int k = 0; k < 16; k++) r[8*k +: 8] = v[127-8*k -: 8];
        return r;
    endfunction

endpackage

// File: rtl/ipf_hdr_match.sv
`timescale 1ns/1ps
// Module: ipf_hdr_match
// Combinational header inspection for one beat. It classifies the frame
// on the first beat and reports whether the header bytes in the current
// beat break the match. It also flags the beat that completes the
// destination address.
// Assumes DATA_W = 128 (16 little-endian byte lanes). Local addresses
// arrive already byte-swapped, so byte k of the address sits in lane k.
module ipf_hdr_match
    import ipf_pkg::*;
#(
    parameter int DATA_W = 128,
    parameter int POS_W  = 3
) (
    input  logic [POS_W-1:0]  pos,
    input  frame_kind_e       kind_q,
    input  logic [DATA_W-1:0] data,
    input  logic [31:0]       loc4_sw,
    input  logic [127:0]      loc6_sw,
    output frame_kind_e       kind_now,
    output logic              bad_now,
    output logic              decide
);

    logic unused_lanes;
    assign unused_lanes = ^data;

    // Per-position comparison of header lanes against the local address
    always_comb begin
        kind_now = kind_q;
        bad_now  = 1'b0;
        decide   = 1'b0;
        if (pos == POS_W'(0)) begin
            if (data[111:96] == ETYPE_V4_LANES) begin
                kind_now = FK_V4;
                bad_now  = (data[119:116] != VER_V4);
            end else if (data[111:96] == ETYPE_V6_LANES) begin
                kind_now = FK_V6;
                bad_now  = (data[119:116] != VER_V6);
            end else begin
                kind_now = FK_OTHER;
            end
        end else if (pos == POS_W'(1)) begin
            if (kind_q == FK_V4) bad_now = (data[127:112] != loc4_sw[15:0]);
        end else if (pos == POS_W'(2)) begin
            if (kind_q == FK_V4) begin
                bad_now = (data[15:0] != loc4_sw[31:16]);
                decide  = 1'b1;
            end else if (kind_q == FK_V6) begin
                bad_now = (data[127:48] != loc6_sw[79:0]);
            end
        end else if (pos == POS_W'(3)) begin
            if (kind_q == FK_V6) begin
                bad_now = (data[47:0] != loc6_sw[127:80]);
                decide  = 1'b1;
            end
        end
    end

endmodule

// File: rtl/ipf_frame_ctl.sv
`timescale 1ns/1ps
// Module: ipf_frame_ctl
// Per-frame tracking: beat position (saturating), frame kind, sticky
// mismatch, and drop state after a rejection. Assumes take and abort_in
// are mutually exclusive and already qualified by the input handshake.
module ipf_frame_ctl
    import ipf_pkg::*;
#(
    parameter int POS_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             filter_en,
    input  logic             take,
    input  logic             abort_in,
    input  logic             last,
    input  frame_kind_e      kind_now,
    input  logic             bad_now,
    input  logic             decide,
    output logic [POS_W-1:0] pos_q,
    output frame_kind_e      kind_q,
    output logic             drop_q,
    output logic             reject
);

    localparam logic [POS_W-1:0] POS_SAT = POS_W'(POS_LIMIT);

    logic bad_q;
    logic bad_all;

    // Mismatch seen anywhere in this frame so far, including this beat
    assign bad_all = bad_q | bad_now;
    // Reject on the deciding beat when filtering and something mismatched
    assign reject  = take && decide && bad_all && filter_en && !drop_q;

    // Advance or restart the frame state on each accepted beat or cancel
    always_ff @(posedge clk) begin
        if (!rst_n || abort_in || (take && last)) begin
            pos_q  <= '0;
            kind_q <= FK_OTHER;
            bad_q  <= 1'b0;
            drop_q <= 1'b0;
        end else if (take) begin
            pos_q  <= (pos_q == POS_SAT) ? pos_q : pos_q + POS_W'(1);
            kind_q <= kind_now;
            bad_q  <= bad_all;
            if (reject) drop_q <= 1'b1;
        end
    end

endmodule

// File: rtl/ipf_out_reg.sv
`timescale 1ns/1ps
// Module: ipf_out_reg
// Single output register stage. A load happens only while the stage is
// empty or draining (the caller guarantees this). A cancel empties the
// stage and raises abort until the downstream accepts it.
module ipf_out_reg #(
    parameter int DATA_W  = 128,
    parameter int BYTES_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               set_abort,
    input  logic [DATA_W-1:0]  in_data,
    input  logic [BYTES_W-1:0] in_bytes,
    input  logic               in_last,
    input  logic               m_ready,
    output logic               m_valid,
    output logic [DATA_W-1:0]  m_data,
    output logic [BYTES_W-1:0] m_bytes,
    output logic               m_last,
    output logic               m_abort
);

    // Valid/abort control of the output stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_valid <= 1'b0;
            m_abort <= 1'b0;
        end else if (set_abort) begin
            m_valid <= 1'b0;
            m_abort <= 1'b1;
        end else begin
            if (load)         m_valid <= 1'b1;
            else if (m_ready) m_valid <= 1'b0;
            if (!m_valid || m_ready) m_abort <= 1'b0;
        end
    end

    // Beat payload capture
    always_ff @(posedge clk) begin
        if (load) begin
            m_data  <= in_data;
            m_bytes <= in_bytes;
            m_last  <= in_last;
        end
    end

endmodule

// File: rtl/ip_dest_filter.sv
`timescale 1ns/1ps
// Module: ip_dest_filter
// Inline IPv4/IPv6 destination filter on a 16-byte-per-beat frame stream.
// It forwards beats through one register. On a header mismatch while
// filter_en is high, it cancels the frame with m_abort in place of the
// deciding beat and swallows the rest of that frame.
// Assumes untagged Ethernet frames and an IPv4 header without options.
module ip_dest_filter
    import ipf_pkg::*;
#(
    parameter int DATA_W = 128,
    parameter int POS_W  = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       filter_en,
    input  logic [31:0]                local_v4,
    input  logic [127:0]               local_v6,
    input  logic                       s_valid,
    output logic                       s_ready,
    input  logic [DATA_W-1:0]          s_data,
    input  logic [$clog2(DATA_W/8)-1:0] s_bytes,
    input  logic                       s_last,
    input  logic                       s_abort,
    output logic                       m_valid,
    input  logic                       m_ready,
    output logic [DATA_W-1:0]          m_data,
    output logic [$clog2(DATA_W/8)-1:0] m_bytes,
    output logic                       m_last,
    output logic                       m_abort
);

    localparam int BYTES_W = $clog2(DATA_W/8);

    logic [POS_W-1:0] pos_q;
    frame_kind_e      kind_q, kind_now;
    logic             bad_now, decide, drop_q, reject;
    logic             take, abort_in, load, set_abort;
    logic [31:0]      loc4_sw;
    logic [127:0]     loc6_sw;

    // Addresses rearranged so byte k of the address sits in lane k
    assign loc4_sw = swap_bytes32(local_v4);
    assign loc6_sw = swap_bytes128(local_v6);

    // Handshake: always ready while dropping, else when the stage frees up
    assign s_ready   = drop_q || !m_valid || m_ready;
    assign abort_in  = s_abort && s_ready;
    assign take      = s_valid && s_ready && !s_abort;
    assign load      = take && !drop_q && !reject;
    assign set_abort = reject || abort_in;

    ipf_hdr_match #(.DATA_W(DATA_W), .POS_W(POS_W)) u_match (
        .pos      (pos_q),
        .kind_q   (kind_q),
        .data     (s_data),
        .loc4_sw  (loc4_sw),
        .loc6_sw  (loc6_sw),
        .kind_now (kind_now),
        .bad_now  (bad_now),
        .decide   (decide)
    );

    ipf_frame_ctl #(.POS_W(POS_W)) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .filter_en (filter_en),
        .take      (take),
        .abort_in  (abort_in),
        .last      (s_last),
        .kind_now  (kind_now),
        .bad_now   (bad_now),
        .decide    (decide),
        .pos_q     (pos_q),
        .kind_q    (kind_q),
        .drop_q    (drop_q),
        .reject    (reject)
    );

    ipf_out_reg #(.DATA_W(DATA_W), .BYTES_W(BYTES_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .set_abort (set_abort),
        .in_data   (s_data),
        .in_bytes  (s_bytes),
        .in_last   (s_last),
        .m_ready   (m_ready),
        .m_valid   (m_valid),
        .m_data    (m_data),
        .m_bytes   (m_bytes),
        .m_last    (m_last),
        .m_abort   (m_abort)
    );

endmodule

// File: rtl/ipf_checker.sv
`timescale 1ns/1ps
// Module: ipf_checker
// Port-level properties of ip_dest_filter, bound into every instance.
module ipf_checker #(
    parameter int DATA_W = 128
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        filter_en,
    input logic                        s_ready,
    input logic                        s_abort,
    input logic                        m_valid,
    input logic                        m_ready,
    input logic [DATA_W-1:0]           m_data,
    input logic [$clog2(DATA_W/8)-1:0] m_bytes,
    input logic                        m_last,
    input logic                        m_abort
);

    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (!m_valid && !m_abort));

    p_stall_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_bytes) && $stable(m_last)));

    p_ready_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!m_valid || m_ready) |-> s_ready);

    p_promisc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        m_abort |-> ($past(filter_en) || $past(s_abort && s_ready)));

    p_cancel_fwd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (s_abort && s_ready) |=> (m_abort && !m_valid));

    p_abort_alone_r11: assert property (@(posedge clk) disable iff (!rst_n)
        m_abort |-> !m_valid);

endmodule

bind ip_dest_filter ipf_checker #(.DATA_W(DATA_W)) u_ipf_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .filter_en (filter_en),
    .s_ready   (s_ready),
    .s_abort   (s_abort),
    .m_valid   (m_valid),
    .m_ready   (m_ready),
    .m_data    (m_data),
    .m_bytes   (m_bytes),
    .m_last    (m_last),
    .m_abort   (m_abort)
);

// File: tb/test_ip_dest_filter.sv
`timescale 1ns/1ps
// Bench: directed corner frames plus seeded random frames, compared
// event by event against a byte-indexed reference model.
module test_ip_dest_filter;

    localparam int DW = 128;
    localparam int BW = 4;

    logic          clk;
    logic          rst_n;
    logic          filter_en;
    logic [31:0]   loc4;
    logic [127:0]  loc6;
    logic          s_valid, s_ready, s_last, s_abort;
    logic [DW-1:0] s_data;
    logic [BW-1:0] s_bytes;
    logic          m_valid, m_ready, m_last, m_abort;
    logic [DW-1:0] m_data;
    logic [BW-1:0] m_bytes;

    ip_dest_filter #(.DATA_W(DW)) i_ip_dest_filter (
        .clk(clk), .rst_n(rst_n), .filter_en(filter_en),
        .local_v4(loc4), .local_v6(loc6),
        .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
        .s_bytes(s_bytes), .s_last(s_last), .s_abort(s_abort),
        .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
        .m_bytes(m_bytes), .m_last(m_last), .m_abort(m_abort)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int rdy_mode = 0;  // 0 random, 1 always high, 2 always low

    logic [DW-1:0]  fb [0:7];
    logic [BW-1:0]  lb;
    logic [134:0]   expq[$];
    logic [134:0]   gotq[$];

    task automatic chk(input bit ok, input string req,
                       input logic [134:0] act, input logic [134:0] exv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exv);
        end
    endtask

    function automatic logic [7:0] fbyte(input int idx);
        return fb[idx/16][(idx%16)*8 +: 8];
    endfunction

    task automatic set_byte(input int idx, input logic [7:0] v);
        fb[idx/16][(idx%16)*8 +: 8] = v;
    endtask

    // kind: 0 other, 1 IPv4, 2 IPv6; bad_k = index of a corrupted address byte
    task automatic make_frame(input int kind, input bit bad_ver, input int bad_k);
        for (int i = 0; i < 8; i++) fb[i] = {$urandom, $urandom, $urandom, $urandom};
        lb = BW'($urandom);
        if (kind == 0) begin
            set_byte(12, 8'h08); set_byte(13, 8'h06);
        end else if (kind == 1) begin
            set_byte(12, 8'h08); set_byte(13, 8'h00);
            set_byte(14, {bad_ver ? 4'd6 : 4'd4, 4'd5});
            for (int k = 0; k < 4; k++)
                set_byte(30 + k, loc4[31-8*k -: 8] ^ ((k == bad_k) ? 8'h5A : 8'h00));
        end else begin
            set_byte(12, 8'h86); set_byte(13, 8'hDD);
            set_byte(14, {bad_ver ? 4'd4 : 4'd6, 4'd0});
            for (int k = 0; k < 16; k++)
                set_byte(38 + k, loc6[127-8*k -: 8] ^ ((k == bad_k) ? 8'hA5 : 8'h00));
        end
    endtask

    // Reference model: expected output events for a whole frame of nb beats
    task automatic build_exp(input int nb);
        logic [7:0] b14;
        bit v4, v6, bad, rej;
        int d;
        v4 = (fbyte(12) == 8'h08) && (fbyte(13) == 8'h00);
        v6 = (fbyte(12) == 8'h86) && (fbyte(13) == 8'hDD);
        b14 = fbyte(14);
        bad = 1'b0;
        d = 99;
        if (v4) begin
            d = 2;
            bad = (b14[7:4] != 4'd4);
            for (int k = 0; k < 4; k++) if (fbyte(30 + k) != loc4[31-8*k -: 8]) bad = 1'b1;
        end else if (v6) begin
            d = 3;
            bad = (b14[7:4] != 4'd6);
            for (int k = 0; k < 16; k++) if (fbyte(38 + k) != loc6[127-8*k -: 8]) bad = 1'b1;
        end
        rej = filter_en && (v4 || v6) && (nb > d) && bad;
        for (int i = 0; i < nb; i++) begin
            if (rej && i == d) begin
                expq.push_back({2'd2, 133'd0});
                break;
            end
            expq.push_back({2'd1, (i == nb - 1), (i == nb - 1) ? lb : 4'd0, fb[i]});
        end
    endtask

    // Send beats 0..nsend-1; from beat 'probe' on, hold m_ready low and expect s_ready high
    task automatic send_frame(input int nb, input int nsend, input int probe);
        for (int i = 0; i < nsend; i++) begin
            s_valid = 1'b1;
            s_data  = fb[i];
            s_last  = (i == nb - 1);
            s_bytes = (i == nb - 1) ? lb : '0;
            if (probe >= 0 && i >= probe) rdy_mode = 2;
            @(negedge clk);
            if (probe >= 0 && i >= probe)
                chk(s_ready === 1'b1, "R10 swallow", 135'(s_ready), 135'(1));
            while (!s_ready) @(negedge clk);
            @(posedge clk); #1;
            s_valid = 1'b0;
            if (rdy_mode == 0) repeat ($urandom % 3) begin @(posedge clk); #1; end
        end
        s_valid = 1'b0;
        s_last  = 1'b0;
    endtask

    task automatic send_cancel();
        s_valid = 1'b0;
        s_abort = 1'b1;
        @(negedge clk);
        while (!s_ready) @(negedge clk);
        @(posedge clk); #1;
        s_abort = 1'b0;
    endtask

    task automatic finish_frame(input string req);
        int n;
        rdy_mode = 1;
        repeat (6) begin @(posedge clk); #1; end
        chk(gotq.size() == expq.size(), {req, " event count"},
            135'(gotq.size()), 135'(expq.size()));
        n = (gotq.size() < expq.size()) ? gotq.size() : expq.size();
        for (int i = 0; i < n; i++) chk(gotq[i] === expq[i], req, gotq[i], expq[i]);
        gotq.delete();
        expq.delete();
        rdy_mode = 0;
    endtask

    task automatic run_frame(input int nb, input int kind, input bit bad_ver,
                             input int bad_k, input string req);
        make_frame(kind, bad_ver, bad_k);
        build_exp(nb);
        send_frame(nb, nb, -1);
        finish_frame(req);
    endtask

    // Output monitor, sampled between edges
    always @(negedge clk) begin
        if (rst_n) begin
            if (m_valid && m_ready) gotq.push_back({2'd1, m_last, m_bytes, m_data});
            if (m_abort && (!m_valid || m_ready)) gotq.push_back({2'd2, 133'd0});
            if (m_abort) chk(!m_valid, "R11 abort with valid", 135'(m_valid), 135'(0));
        end
    end

    // Downstream ready driver
    initial begin
        m_ready = 1'b0;
        forever begin
            @(posedge clk); #2;
            if (rdy_mode == 1)      m_ready = 1'b1;
            else if (rdy_mode == 2) m_ready = 1'b0;
            else                    m_ready = ($urandom % 4) != 0;
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; filter_en = 1'b1;
        loc4 = 32'hC0A8_0F01;
        loc6 = 128'h2001_0DB8_0000_1234_5678_9ABC_DEF0_0042;
        s_valid = 1'b0; s_abort = 1'b0; s_last = 1'b0;
        s_data = '0; s_bytes = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(!m_valid && !m_abort, "R1 reset idle", 135'({m_valid, m_abort}), 135'(0));
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(posedge clk); #1;

        run_frame(4, 0, 0, -1, "R3 other ethertype");
        run_frame(1, 0, 0, -1, "R3 single beat");
        run_frame(5, 1, 0, -1, "R4 ipv4 match");
        run_frame(5, 1, 0, 3, "R5 ipv4 last byte off");
        run_frame(4, 1, 0, 0, "R5 ipv4 first byte off");
        run_frame(3, 1, 1, -1, "R5 ipv4 version, ends on verdict");
        run_frame(6, 2, 0, -1, "R6 ipv6 match");
        run_frame(6, 2, 0, 15, "R6 ipv6 last byte off");
        run_frame(4, 2, 0, 0, "R6 ipv6 first byte off");
        run_frame(5, 2, 1, -1, "R6 ipv6 version");
        run_frame(2, 1, 0, 1, "R8 ipv4 runt");
        run_frame(3, 2, 0, 2, "R8 ipv6 runt");
        run_frame(1, 2, 0, 5, "R8 one-beat runt");

        filter_en = 1'b0;
        run_frame(5, 1, 0, 2, "R7 promiscuous ipv4");
        run_frame(6, 2, 1, -1, "R7 promiscuous ipv6");
        filter_en = 1'b1;

        // R10: rejected frame, remaining beats offered with m_ready low
        make_frame(1, 0, 2);
        build_exp(6);
        rdy_mode = 1;
        send_frame(6, 6, 3);
        finish_frame("R10 drop remainder");

        // R9: cancel mid-frame, then a clean frame must not inherit state
        make_frame(1, 0, 1);
        for (int i = 0; i < 2; i++) expq.push_back({2'd1, 1'b0, 4'd0, fb[i]});
        expq.push_back({2'd2, 133'd0});
        send_frame(5, 2, -1);
        send_cancel();
        finish_frame("R9 forwarded cancel");
        run_frame(4, 1, 0, -1, "R9 fresh frame after cancel");

        // Random mix under back-pressure
        for (int f = 0; f < 80; f++) begin
            int nb, kind, bk;
            bit bv;
            nb   = 1 + ($urandom % 6);
            kind = $urandom % 3;
            bv   = ($urandom % 5) == 0;
            bk   = ($urandom % 2) ? int'($urandom % ((kind == 2) ? 16 : 4)) : -1;
            filter_en = ($urandom % 6) != 0;
            run_frame(nb, kind, bv, bk, "R2 random frame");
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule